// File: doc/BRIEF.md
# Read-Path Memory Fault Injector

This block sits on the read-data path of a two-channel memory controller. It corrupts chosen ECC device symbols in the cache lines that pass through it, so that the downstream error detection and correction logic can be tested. A cache line is made of two halves. Each half is split into `N_DEV` symbols of 16 bits, and the lower half sits in the low-order bits of the line. Each channel has two mask registers, loaded through a plain register-write port. These registers choose the half-line, hold an enable bit, and give two device pointers, each with a 16-bit XOR pattern.

A shared control byte decides when injection is armed. Its low nibble is the start condition and its high nibble is the stop condition. In one-shot mode the armed state clears on the beat that is corrupted. To arm again, software must first write a "never start" code and then write a "start now" code. Writing "start now" a second time does nothing.

Read data moves on a valid/ready stream with one register stage. A beat is accepted when `in_valid` and `in_ready` are both high, and it appears on the output one cycle later. `in_ready` is high when the output stage is empty or when the consumer is taking the current output. While `out_valid` is high and `out_ready` is low, the output beat holds still and no new beat is accepted.

Top module: `mem_fault_inject`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, every mask register and the control byte are zero, and injection is disarmed.
- R2: A beat that is not injected leaves the block unchanged, with `out_injected` 0. This covers a disarmed block, a clear enable bit, and a half-line select of 00.
- R3: The half-line select is mask0 bits 29:28. 01 corrupts only the lower half, 10 only the upper half, 11 both halves, and 00 nothing.
- R4: mask0 bits 4:0 hold pointer A, and its XOR pattern is mask0 bits 25:10. mask0 bits 9:5 hold pointer B, and its XOR pattern is mask1 bits 15:0. Pointer value d selects symbol d of each chosen half, at bit offset (half*N_DEV+d)*16. When both pointers select the same symbol, both patterns are applied. A pointer of N_DEV or more selects no symbol.
- R5: Register addresses are 0 for channel 0 mask0, 1 for channel 0 mask1, 2 for channel 1 mask0, 3 for channel 1 mask1, and 4 for the control byte (low 8 data bits). Addresses 5 to 7 are ignored. Each beat uses the registers of the channel given by `in_chan`.
- R6: mask0 bit 27 enables injection on its channel. When it is 0, that channel is never corrupted.
- R7: Writing control bits 3:0 = 1011 arms injection, but only if the stored start nibble was not already 1011. Writing any other start nibble, including 1010, disarms it.
- R8: When control bits 7:4 are 1011, injection stays armed across beats. Any other stop nibble, including 1010, clears the armed state on the beat that is injected. If a control write lands in the same cycle, the write's effect wins.
- R9: After a one-shot injection, rewriting 1011 alone does not re-arm. Writing 1010 and then 1011 re-arms for exactly one more injection.
- R10: A beat appears on the output one cycle after it is accepted. `in_ready` = !out_valid || out_ready. A stalled output keeps `out_valid`, `out_data`, `out_chan` and `out_injected` stable.
- R11: `out_injected` is 1 exactly for the output beats that were corrupted: armed, enabled, and half-select not 00. It is never 1 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (see R5) |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_chan | input | 1 | Channel of the input beat |
| in_data | input | 2*N_DEV*16 | Cache line; lower half in low bits |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_chan | output | 1 | Channel of the output beat |
| out_data | output | 2*N_DEV*16 | Possibly corrupted cache line |
| out_injected | output | 1 | Beat was corrupted |

## Verification
The armed flag is the only hidden state that outlives a single beat. If it is wrong, the effect reaches the ports on the next accepted beat. A spurious or missing corruption shows at once in `out_data` and `out_injected`, one cycle after acceptance. A wrong channel bank or pointer decode shows as XOR differences in the wrong 16-bit symbol of that same beat. Stall errors show as output fields that change while `out_ready` is low. The reference model is compared every cycle, so each of these faults is caught in the first cycle it becomes visible.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam int SYM_W = 16;
  localparam int PTR_W = 5;

  localparam logic [3:0] CODE_OFF = 4'b1010;
  localparam logic [3:0] CODE_ON  = 4'b1011;

  localparam logic [2:0] ADDR_CTL = 3'd4;

  typedef struct packed {
    logic [1:0]       half_sel;
    logic             enable;
    logic [SYM_W-1:0] pat_a;
    logic [PTR_W-1:0] ptr_b;
    logic [PTR_W-1:0] ptr_a;
    logic [SYM_W-1:0] pat_b;
  } inj_cfg_t;
endpackage

// File: rtl/fi_mask_bank.sv
module fi_mask_bank
  import fi_pkg::*;
#(
  parameter int N_CH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_chan,
  output inj_cfg_t    cfg
);
  logic [31:0]      m0 [N_CH];
  logic [SYM_W-1:0] m1 [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        m0[c] <= '0;
        m1[c] <= '0;
      end else if (wr_en && !wr_addr[2] && (wr_addr[1] == 1'(c))) begin
        if (wr_addr[0]) m1[c] <= wr_data[SYM_W-1:0];
        else            m0[c] <= wr_data;
      end
    end
  end

  always_comb begin
    cfg.half_sel = m0[rd_chan][29:28];
    cfg.enable   = m0[rd_chan][27];
    cfg.pat_a    = m0[rd_chan][25:10];
    cfg.ptr_b    = m0[rd_chan][9:5];
    cfg.ptr_a    = m0[rd_chan][4:0];
    cfg.pat_b    = m1[rd_chan];
  end
endmodule

// File: rtl/fi_arm.sv
module fi_arm
  import fi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       inj_fire,
  output logic       armed,
  output logic       oneshot,
  output logic [3:0] start_q
);
  logic [7:0] ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      armed <= 1'b0;
    end else if (ctl_we) begin
      ctl_q <= ctl_wdata;
      if (ctl_wdata[3:0] == CODE_ON) begin
        if (ctl_q[3:0] != CODE_ON) armed <= 1'b1;
      end else begin
        armed <= 1'b0;
      end
    end else if (inj_fire && oneshot) begin
      armed <= 1'b0;
    end
  end

  assign oneshot = (ctl_q[7:4] != CODE_ON);
  assign start_q = ctl_q[3:0];
endmodule

// File: rtl/fi_corrupt.sv
module fi_corrupt
  import fi_pkg::*;
#(
  parameter int N_DEV = 4
) (
  input  logic [2*N_DEV*SYM_W-1:0] line_i,
  input  inj_cfg_t                 cfg,
  input  logic                     active,
  output logic [2*N_DEV*SYM_W-1:0] line_o
);
  for (genvar h = 0; h < 2; h++) begin : g_half
    for (genvar d = 0; d < N_DEV; d++) begin : g_dev
      localparam int LO = (h * N_DEV + d) * SYM_W;
      logic hit_a, hit_b;
      assign hit_a = active && cfg.half_sel[h] && (cfg.ptr_a == PTR_W'(d));
      assign hit_b = active && cfg.half_sel[h] && (cfg.ptr_b == PTR_W'(d));
      assign line_o[LO +: SYM_W] = line_i[LO +: SYM_W]
                                 ^ (hit_a ? cfg.pat_a : '0)
                                 ^ (hit_b ? cfg.pat_b : '0);
    end
  end
endmodule

// File: rtl/mem_fault_inject.sv
module mem_fault_inject
  import fi_pkg::*;
#(
  parameter int N_DEV = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [2:0]                 reg_addr,
  input  logic [31:0]                reg_wdata,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic                       in_chan,
  input  logic [2*N_DEV*SYM_W-1:0]   in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic                       out_chan,
  output logic [2*N_DEV*SYM_W-1:0]   out_data,
  output logic                       out_injected
);
  localparam int LINE_W = 2 * N_DEV * SYM_W;

  inj_cfg_t          cfg;
  logic              armed, oneshot, ctl_we, in_fire, inj_fire;
  logic [3:0]        start_q;
  logic [LINE_W-1:0] line_mod;

  assign ctl_we   = reg_we && (reg_addr == ADDR_CTL);
  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;
  assign inj_fire = in_fire && armed && cfg.enable && (cfg.half_sel != 2'b00);

  fi_mask_bank #(.N_CH(2)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .rd_chan(in_chan), .cfg(cfg)
  );

  fi_arm u_arm (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(reg_wdata[7:0]),
    .inj_fire(inj_fire), .armed(armed), .oneshot(oneshot), .start_q(start_q)
  );

  fi_corrupt #(.N_DEV(N_DEV)) u_corrupt (
    .line_i(in_data), .cfg(cfg), .active(inj_fire), .line_o(line_mod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_injected <= 1'b0;
      out_chan     <= 1'b0;
      out_data     <= '0;
    end else if (in_fire) begin
      out_valid    <= 1'b1;
      out_injected <= inj_fire;
      out_chan     <= in_chan;
      out_data     <= line_mod;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
      out_injected <= 1'b0;
    end
  end
endmodule

// File: rtl/fi_checker.sv
module fi_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_chan,
  input logic [127:0] out_data,
  input logic       out_injected,
  input logic       armed,
  input logic       oneshot,
  input logic       ctl_we,
  input logic [3:0] wr_start,
  input logic [3:0] start_q,
  input logic       inj_fire
);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                && $stable(out_chan) && $stable(out_injected));

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_no_inject_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !armed |=> !out_injected);

  assert_flag_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_injected |-> out_valid);

  assert_disarm_on_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && wr_start != 4'b1011 |=> !armed);

  assert_oneshot_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inj_fire && oneshot && !ctl_we |=> !armed);

  assert_no_rearm_repeat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && wr_start == 4'b1011 && start_q == 4'b1011 && !armed |=> !armed);
endmodule

bind mem_fault_inject fi_checker u_fi_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
  .out_data(out_data[127:0]), .out_injected(out_injected), .armed(armed),
  .oneshot(oneshot), .ctl_we(ctl_we), .wr_start(reg_wdata[3:0]),
  .start_q(start_q), .inj_fire(inj_fire)
);

// File: tb/test_mem_fault_inject.sv
module test_mem_fault_inject;
  localparam int N  = 4;
  localparam int LW = 2 * N * 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          reg_we = 0;
  logic [2:0]    reg_addr = 0;
  logic [31:0]   reg_wdata = 0;
  logic          in_valid = 0;
  logic          in_ready;
  logic          in_chan = 0;
  logic [LW-1:0] in_data = 0;
  logic          out_valid;
  logic          out_ready = 1;
  logic          out_chan;
  logic [LW-1:0] out_data;
  logic          out_injected;

  always #2 clk = ~clk;

  mem_fault_inject #(.N_DEV(N)) i_mem_fault_inject (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_chan(out_chan), .out_data(out_data),
    .out_injected(out_injected)
  );

  int    checks = 0, failures = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  logic [31:0]   bm0 [2];
  logic [15:0]   bm1 [2];
  logic [7:0]    bctl;
  bit            barm;
  bit            mv, minj, mch;
  logic [LW-1:0] mdata;
  bit            last_fire;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] model_corrupt(input logic [LW-1:0] d, input bit ch);
    logic [LW-1:0] r = d;
    for (int h = 0; h < 2; h++) begin
      if (bm0[ch][28 + h]) begin
        for (int dv = 0; dv < N; dv++) begin
          if (int'(bm0[ch][4:0]) == dv) r[(h*N+dv)*16 +: 16] ^= bm0[ch][25:10];
          if (int'(bm0[ch][9:5]) == dv) r[(h*N+dv)*16 +: 16] ^= bm1[ch];
        end
      end
    end
    return r;
  endfunction

  task automatic model_reset();
    bm0[0] = 0; bm0[1] = 0; bm1[0] = 0; bm1[1] = 0;
    bctl = 0; barm = 0; mv = 0; minj = 0; mch = 0; mdata = 0;
  endtask

  // one clock: inputs are already applied at the current falling edge
  task automatic step();
    bit rdy, fire, inj;
    logic [LW-1:0] nd;
    #1;
    rdy = !mv || out_ready;
    chk(in_ready == rdy, "R10", "in_ready", LW'(in_ready), LW'(rdy));
    fire = in_valid && rdy;
    inj  = fire && barm && bm0[in_chan][27] && (bm0[in_chan][29:28] != 2'b00);
    nd   = inj ? model_corrupt(in_data, in_chan) : in_data;
    last_fire = fire;
    if (fire) begin
      mv = 1; minj = inj; mch = in_chan; mdata = nd;
    end else if (out_ready) begin
      mv = 0; minj = 0;
    end
    if (reg_we && reg_addr == 3'd4) begin
      if (reg_wdata[3:0] == 4'b1011) begin
        if (bctl[3:0] != 4'b1011) barm = 1;
      end else barm = 0;
      bctl = reg_wdata[7:0];
    end else if (inj && bctl[7:4] != 4'b1011) begin
      barm = 0;
    end
    if (reg_we && reg_addr < 3'd4) begin
      if (reg_addr[0]) bm1[reg_addr[1]] = reg_wdata[15:0];
      else             bm0[reg_addr[1]] = reg_wdata;
    end
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == mv, cur_req, "out_valid", LW'(out_valid), LW'(mv));
    if (mv) begin
      chk(out_data == mdata, cur_req, "out_data", out_data, mdata);
      chk(out_injected == minj, cur_req, "out_injected", LW'(out_injected), LW'(minj));
      chk(out_chan == mch, cur_req, "out_chan", LW'(out_chan), LW'(mch));
    end else begin
      chk(out_injected == 1'b0, "R11", "out_injected idle", LW'(out_injected), '0);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic send(input bit ch, input logic [LW-1:0] d);
    in_valid = 1; in_chan = ch; in_data = d;
    for (int k = 0; k < 50; k++) begin
      step();
      if (last_fire) break;
    end
    in_valid = 0;
  endtask

  function automatic logic [31:0] mk0(input logic [1:0] hs, input bit en,
      input logic [15:0] pa, input logic [4:0] pb, input logic [4:0] pta);
    return {2'b00, hs, en, 1'b0, pa, pb, pta};
  endfunction

  function automatic logic [LW-1:0] rline();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] d;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    #1;
    chk(out_valid == 0, "R1", "out_valid after reset", LW'(out_valid), '0);
    chk(in_ready == 1, "R1", "in_ready after reset", LW'(in_ready), LW'(1));
    chk(out_injected == 0, "R1", "out_injected after reset", LW'(out_injected), '0);
    @(negedge clk);

    // R2/R7: fully configured but never started -> pass-through
    cur_req = "R2";
    wr(3'd0, mk0(2'b11, 1, 16'hFFFF, 5'd1, 5'd0));
    wr(3'd1, 32'h0000_AAAA);
    d = rline();
    send(0, d);
    chk(out_data == d && !out_injected, "R2", "unarmed pass-through", out_data, d);
    wr(3'd4, 32'h0000_00AA);
    send(0, rline());

    // R8/R3/R4: continuous mode, both halves
    cur_req = "R8";
    wr(3'd4, 32'h0000_00BB);
    for (int i = 0; i < 3; i++) send(0, rline());
    cur_req = "R3";
    wr(3'd0, mk0(2'b01, 1, 16'h00FF, 5'd31, 5'd2));
    d = rline();
    send(0, d);
    chk(out_data == (d ^ (LW'(16'h00FF) << 32)) && out_injected, "R3",
        "lower half only", out_data, d ^ (LW'(16'h00FF) << 32));
    cur_req = "R4";
    wr(3'd0, mk0(2'b10, 1, 16'h0F0F, 5'd1, 5'd1));
    wr(3'd1, 32'h0000_F000);
    d = rline();
    send(0, d);
    chk(out_data == (d ^ (LW'(16'hFF0F) << 80)), "R4", "same symbol both patterns",
        out_data, d ^ (LW'(16'hFF0F) << 80));
    wr(3'd0, mk0(2'b11, 1, 16'h1234, 5'd7, 5'd4));
    d = rline();
    send(0, d);
    chk(out_data == d && out_injected, "R4", "pointers out of range",
        out_data, d);

    // R5/R6: channel 1 disabled, then enabled; channel 0 unaffected; bad address ignored
    cur_req = "R6";
    wr(3'd2, mk0(2'b11, 0, 16'h5555, 5'd3, 5'd0));
    wr(3'd3, 32'h0000_3333);
    d = rline();
    send(1, d);
    chk(out_data == d && !out_injected, "R6", "enable clear", out_data, d);
    cur_req = "R5";
    wr(3'd2, mk0(2'b11, 1, 16'h5555, 5'd3, 5'd0));
    wr(3'd6, 32'hFFFF_FFFF);
    send(1, rline());
    send(0, rline());
    send(1, rline());

    // R9: one-shot and re-arm rules
    cur_req = "R9";
    wr(3'd4, 32'h0000_00AB);
    d = rline();
    send(1, d);
    chk(out_injected == 1, "R8", "one-shot first beat", LW'(out_injected), LW'(1));
    send(1, rline());
    chk(out_injected == 0, "R8", "one-shot second beat", LW'(out_injected), '0);
    wr(3'd4, 32'h0000_00AB);
    send(1, rline());
    chk(out_injected == 0, "R9", "repeat start no rearm", LW'(out_injected), '0);
    wr(3'd4, 32'h0000_00AA);
    wr(3'd4, 32'h0000_00AB);
    wr(3'd2, mk0(2'b00, 1, 16'h5555, 5'd3, 5'd0));
    send(1, rline());
    chk(out_injected == 0, "R3", "reserved half select", LW'(out_injected), '0);
    wr(3'd2, mk0(2'b10, 1, 16'h5555, 5'd3, 5'd0));
    send(1, rline());
    chk(out_injected == 1, "R9", "rearmed once", LW'(out_injected), LW'(1));
    send(1, rline());
    chk(out_injected == 0, "R9", "rearm consumed", LW'(out_injected), '0);

    // R10/R11: random traffic with back-pressure, continuous and one-shot mixes
    cur_req = "R10";
    wr(3'd4, 32'h0000_00AA);
    wr(3'd4, 32'h0000_00BB);
    for (int i = 0; i < 400; i++) begin
      out_ready = ($urandom % 3) != 0;
      in_valid  = ($urandom % 4) != 0;
      in_chan   = 1'($urandom);
      in_data   = rline();
      if (i % 50 == 25) begin
        reg_we = 1; reg_addr = 3'($urandom % 5);
        reg_wdata = (reg_addr == 3'd4) ? (($urandom % 2) ? 32'hBB : 32'hAA)
                                       : {2'b00, $urandom} & 32'h3FFF_FFFF;
      end
      step();
      reg_we = 0;
    end
    in_valid = 0;
    out_ready = 1;
    step();
    step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule